// File: doc/BRIEF.md
# GPIO Port with Atomic Bit Set/Clear

This block is an 8-bit general-purpose I/O port. It holds a direction register and a data register, and both are written through a simple register interface. Each pin whose direction bit is 1 is an output and drives its data bit onto the pad. Each pin whose direction bit is 0 is an input. Its output enable is off, and its pad level reaches the read path through a two-flop synchronizer.

A port read gives a mixed byte. Input pins show their synchronized pad level and output pins show their data-register bit. A bit-manipulation unit sets or clears one bit using that same read path. It takes the mixed byte, changes the selected bit and writes the whole byte back to the data register. As a side effect, the data bits of input pins are replaced by the levels seen on their pads. Software that wants those bits kept must keep its own copy of the data byte.

Requests to the bit-manipulation unit use a valid/ready handshake. `bop_ready` is high only while the unit is idle. A requester holds `bop_valid`, `bop_set` and `bop_bit` steady until it sees `bop_ready` high at a rising edge. A request offered while the unit is busy is not accepted and leaves no trace. Plain register writes and reads have no handshake.

Top module: `gpio_rmw_port`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), both registers hold zero. So pad_oe and pad_out are 0x00, busy is 0 and bop_ready is 1.
- R2: pad_oe bit i equals direction bit i; 1 means output, 0 means input (high impedance).
- R3: pad_out carries the data register on every bit; for each output pin, the pad is driven with that pin's data bit.
- R4: With rd_sel = 0, bit i of rd_data is the data bit of pin i when pin i is an output, and the synchronized pad level of pin i when pin i is an input.
- R5: With rd_sel = 1, rd_data returns the direction register.
- R6: A pad change reaches rd_data (rd_sel = 0, input pin) after exactly two rising edges and not after one.
- R7: A bit-set request (bop_set = 1, bit index bop_bit) samples the port read byte in its accept cycle and sets the selected bit. The result is written to the data register, and the data bits of input pins take their sampled pad levels.
- R8: A bit-clear request (bop_set = 0) follows the same sequence as R7 but clears the selected bit.
- R9: A request is accepted at an edge where bop_valid and bop_ready are both 1. busy is 1 for the following cycle, and the data register changes at the edge that ends that cycle. bop_ready equals the inverse of busy.
- R10: A request offered while busy is 1 is ignored. It causes no second write, and pad_out keeps the first result.
- R11: A plain write (wr_en = 1) takes effect at the next rising edge. wr_addr 0 selects the data register and wr_addr 1 selects the direction register.
- R12: A plain write to the data register is dropped when it arrives in the same cycle as an accepted bit request, or during the busy cycle. A plain write to the direction register is never dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_in | input | WIDTH | Pad input levels (asynchronous) |
| pad_out | output | WIDTH | Pad drive values (data register) |
| pad_oe | output | WIDTH | Pad output enables (direction register) |
| wr_en | input | 1 | Plain register write strobe |
| wr_addr | input | 1 | Write target: 0 data, 1 direction |
| wr_data | input | WIDTH | Write value |
| rd_sel | input | 1 | Read select: 0 port value, 1 direction |
| rd_data | output | WIDTH | Read value (combinational) |
| bop_valid | input | 1 | Bit-manipulation request valid |
| bop_ready | output | 1 | Unit idle, request can be accepted |
| bop_set | input | 1 | 1 sets the bit, 0 clears it |
| bop_bit | input | $clog2(WIDTH) | Index of the bit to change |
| busy | output | 1 | Write phase of an accepted request |

## Verification
The hardest situation to reach is a request or a plain data write that collides with the sequencer's busy cycle. Only a requester that ignores back-pressure creates it. The stimulus keeps bop_valid high with a different bit index through the busy cycle, and it drives a plain data write both in the accept cycle and in the write cycle. It then watches pad_out for two more cycles. The overwrite of input-pin data bits is only visible once those pins are switched back to outputs, or on pad_out. Each vector therefore sets direction, data and pad levels, waits out the synchronizer, and compares pad_out after the write phase.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

  // Sequencer phases of the bit-manipulation unit
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_WRITE = 1'b1
  } seq_state_e;

  // Register selects for plain writes and read-back
  localparam logic REG_DATA = 1'b0;
  localparam logic REG_DIR  = 1'b1;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= pad_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_block,   // bit operation owns the data register
  input  logic             wb_en,      // write-back from the sequencer
  input  logic [WIDTH-1:0] wb_data,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);

  logic data_plain_we;
  logic dir_we;

  assign data_plain_we = wr_en && (wr_addr == REG_DATA) && !wr_block;
  assign dir_we        = wr_en && (wr_addr == REG_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wb_en) begin
      data_q <= wb_data;
    end else if (data_plain_we) begin
      data_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= wr_data;
  end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic             rd_sel,
  output logic [WIDTH-1:0] port_val,
  output logic [WIDTH-1:0] rd_data
);

  // Per pin: outputs read back latched data, inputs read the pad
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign port_val[g] = dir_q[g] ? data_q[g] : pin_sync[g];
  end

  always_comb begin
    rd_data = port_val;
    if (rd_sel == REG_DIR) rd_data = dir_q;
  end

endmodule

// File: rtl/gpio_bitop_seq.sv
module gpio_bitop_seq
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int BIT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] port_val,
  input  logic             bop_valid,
  input  logic             bop_set,
  input  logic [BIT_W-1:0] bop_bit,
  output logic             bop_ready,
  output logic             busy,
  output logic             accept,
  output logic             wb_en,
  output logic [WIDTH-1:0] wb_data
);

  seq_state_e       state_q;
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] modified;

  // Read/modify: the live port byte with one bit forced
  always_comb begin
    modified = port_val;
    for (int i = 0; i < WIDTH; i++) begin
      if (bop_bit == BIT_W'(i)) modified[i] = bop_set;
    end
  end

  assign bop_ready = (state_q == SEQ_IDLE);
  assign busy      = (state_q == SEQ_WRITE);
  assign accept    = bop_valid && bop_ready;
  assign wb_en     = busy;
  assign wb_data   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (accept) begin
          pend_q  <= modified;
          state_q <= SEQ_WRITE;
        end
        SEQ_WRITE: state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         pad_in,
  output logic [WIDTH-1:0]         pad_out,
  output logic [WIDTH-1:0]         pad_oe,
  input  logic                     wr_en,
  input  logic                     wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_sel,
  output logic [WIDTH-1:0]         rd_data,
  input  logic                     bop_valid,
  output logic                     bop_ready,
  input  logic                     bop_set,
  input  logic [$clog2(WIDTH)-1:0] bop_bit,
  output logic                     busy
);

  localparam int BIT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] port_val;
  logic [WIDTH-1:0] wb_data;
  logic             wb_en;
  logic             accept;

  gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_block (accept | busy),
    .wb_en    (wb_en),
    .wb_data  (wb_data),
    .data_q   (data_q),
    .dir_q    (dir_q)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
    .dir_q    (dir_q),
    .data_q   (data_q),
    .pin_sync (pin_sync),
    .rd_sel   (rd_sel),
    .port_val (port_val),
    .rd_data  (rd_data)
  );

  gpio_bitop_seq #(.WIDTH(WIDTH), .BIT_W(BIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_val  (port_val),
    .bop_valid (bop_valid),
    .bop_set   (bop_set),
    .bop_bit   (bop_bit),
    .bop_ready (bop_ready),
    .busy      (busy),
    .accept    (accept),
    .wb_en     (wb_en),
    .wb_data   (wb_data)
  );

  // Pad drive: value always presented, enable follows direction
  assign pad_out = data_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_rmw_port_chk.sv
module gpio_rmw_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         pad_in,
  input logic [WIDTH-1:0]         pad_out,
  input logic [WIDTH-1:0]         pad_oe,
  input logic                     wr_en,
  input logic                     wr_addr,
  input logic [WIDTH-1:0]         wr_data,
  input logic                     rd_sel,
  input logic [WIDTH-1:0]         rd_data,
  input logic                     bop_valid,
  input logic                     bop_ready,
  input logic                     bop_set,
  input logic [$clog2(WIDTH)-1:0] bop_bit,
  input logic                     busy
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0 && !busy));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_valid && bop_ready) |=> busy);

  assert_busy_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bop_ready);

  assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_valid && bop_ready && bop_set) |=> ##1 pad_out[$past(bop_bit, 2)]);

  assert_clear_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_valid && bop_ready && !bop_set) |=> ##1 !pad_out[$past(bop_bit, 2)]);

  assert_dir_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> pad_oe == $past(wr_data));

  assert_data_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !busy && !(bop_valid && bop_ready)) |=> pad_out == $past(wr_data));

  if (SYNC_STAGES == 2) begin : g_sync2
    assert_sync_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && !rd_sel && pad_oe == '0) |-> rd_data == $past(pad_in, 2));
  end

endmodule

bind gpio_rmw_port gpio_rmw_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .bop_valid (bop_valid),
  .bop_ready (bop_ready),
  .bop_set   (bop_set),
  .bop_bit   (bop_bit),
  .busy      (busy)
);

// File: tb/sim_gpio_rmw_port.sv
module sim_gpio_rmw_port;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int NVEC       = 8;
  localparam int WATCHDOG   = 20000;

  // {dir, data, pads, ctl, expected data}; ctl bit4 = set, bits2:0 = bit index
  localparam logic [39:0] VEC [NVEC] = '{
    40'h3F_80_40_10_41,
    40'hFF_00_FF_17_80,
    40'h00_AA_55_00_54,
    40'h0F_F0_A5_14_B0,
    40'hF0_3C_0F_05_1F,
    40'hAA_FF_00_01_A8,
    40'h55_00_FF_13_AA,
    40'hC3_81_7E_07_3D
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe, rd_data;
  logic         wr_en = 1'b0, wr_addr = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         bop_valid = 1'b0, bop_set = 1'b0;
  logic [2:0]   bop_bit = '0;
  logic         bop_ready, busy;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_rmw_port #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .bop_valid(bop_valid), .bop_ready(bop_ready),
    .bop_set(bop_set), .bop_bit(bop_bit), .busy(busy)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic plain_write(input logic addr, input logic [W-1:0] val);
    wr_en = 1'b1; wr_addr = addr; wr_data = val;
    step();
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD*2 + 1);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 busy/ready", {6'b0, busy, bop_ready}, 8'h01);
    rd_sel = 1'b1; #1;
    check("R1 dir readback", rd_data, 8'h00);
    rd_sel = 1'b0;
    step();
    rst_n = 1'b1;
    step();

    // Vector table: R2, R3, R4, R7, R8, R9
    for (int v = 0; v < NVEC; v++) begin
      logic [W-1:0] vd, vdat, vp, vexp, mix;
      logic [7:0]   ctl;
      {vd, vdat, vp, ctl, vexp} = VEC[v];
      mix = (vd & vdat) | (~vd & vp);
      plain_write(1'b1, vd);
      plain_write(1'b0, vdat);
      pad_in = vp;
      step(); step(); step();
      check("R2 oe follows dir", pad_oe, vd);
      check("R3 pad_out is data", pad_out, vdat);
      check("R4 port read mix", rd_data, mix);
      bop_valid = 1'b1; bop_set = ctl[4]; bop_bit = ctl[2:0];
      step();
      bop_valid = 1'b0;
      check("R9 busy after accept", {6'b0, busy, bop_ready}, 8'h02);
      check("R9 data not yet written", pad_out, vdat);
      step();
      check(ctl[4] ? "R7 set result" : "R8 clear result", pad_out, vexp);
      check("R9 idle again", {6'b0, busy, bop_ready}, 8'h01);
    end

    // R5: direction readback
    plain_write(1'b1, 8'h5A);
    rd_sel = 1'b1; #1;
    check("R5 dir readback", rd_data, 8'h5A);
    rd_sel = 1'b0;

    // R6: two-edge synchronizer latency on input pins
    plain_write(1'b1, 8'h00);
    pad_in = 8'h00;
    step(); step(); step();
    pad_in = 8'hC3;
    step();
    check("R6 not after one edge", rd_data, 8'h00);
    step();
    check("R6 after two edges", rd_data, 8'hC3);

    // R10: request held through busy cycle is ignored
    plain_write(1'b1, 8'hFF);
    plain_write(1'b0, 8'h00);
    bop_valid = 1'b1; bop_set = 1'b1; bop_bit = 3'd2;
    step();
    bop_bit = 3'd5;
    step();
    bop_valid = 1'b0;
    check("R10 first result", pad_out, 8'h04);
    step(); step();
    check("R10 no second write", pad_out, 8'h04);

    // R12: plain data writes colliding with accept and busy cycles
    plain_write(1'b0, 8'h00);
    bop_valid = 1'b1; bop_set = 1'b1; bop_bit = 3'd1;
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'hF0;
    step();
    bop_valid = 1'b0;
    step();
    wr_en = 1'b0;
    check("R12 data writes dropped", pad_out, 8'h02);
    step();
    check("R12 still bit result", pad_out, 8'h02);

    // R12: direction write during busy still lands
    bop_valid = 1'b1; bop_set = 1'b0; bop_bit = 3'd1;
    step();
    bop_valid = 1'b0;
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h0F;
    step();
    wr_en = 1'b0;
    check("R12 dir write during busy", pad_oe, 8'h0F);
    check("R8 clear during dir change", pad_out, 8'h00);

    // R11: plain write lands at the next edge, not before
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'hF0;
    #1;
    check("R11 before edge", pad_out, 8'h00);
    step();
    wr_en = 1'b0;
    check("R11 data after edge", pad_out, 8'hF0);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h33;
    step();
    wr_en = 1'b0;
    check("R11 dir after edge", pad_oe, 8'h33);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule